// File: doc/BRIEF.md
# Memory-Mapped Stream Bridge

This block lets a processor with a plain load/store bus talk to a streaming coprocessor through three fixed bus addresses. A store to the send address places a 32-bit token in a one-entry outbound slot. The coprocessor sees that slot as a valid flag with data, and consumes the token by pulsing a take strobe for one cycle.

Results travel the other way through a one-entry inbound slot. The coprocessor pushes a token with a strobe while the slot reports that it is not busy. The processor polls a status word until its ready bit is 1, then loads the result address. That load hands back the token and empties the slot.

A store to the send address while the previous token is still unclaimed replaces that token. It also sets a sticky overrun bit, which software can see in the status word. Bus loads are registered, so read data appears one cycle after the read strobe.

Top module: `mmio_stream_bridge`

## Requirements
- R1: A store (bus_we=1) to address 0x80000000 puts bus_wdata on tx_tok and drives tx_avail to 1 from the next cycle.
- R2: A one-cycle tx_take with tx_avail=1 and no store in the same cycle drives tx_avail to 0 from the next cycle.
- R3: A store to 0x80000000 while tx_avail=1 and tx_take=0 replaces tx_tok with the new data and sets an overrun bit that stays 1 until reset.
- R4: rx_push while rx_busy=0 captures rx_data and drives rx_busy to 1 from the next cycle. rx_push while rx_busy=1 changes nothing.
- R5: A load (bus_re=1) from 0x80000004 puts the held inbound token on bus_rdata in the next cycle and drives rx_busy to 0.
- R6: A load from 0x80000008 returns the status word: bit 0 is 1 when an inbound token is waiting unread, bit 1 is the overrun bit, and all other bits are 0.
- R7: A load from any other address returns 0. In any cycle that does not follow a load, bus_rdata is 0.
- R8: Stores to 0x80000004, to 0x80000008 and to other addresses change no state.
- R9: A synchronous active-high rst empties both slots, clears the overrun bit and clears bus_rdata.
- R10: With a two-state copy coprocessor attached, each value sent comes back in order. The status word reads 0 after each result has been loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Bus byte address |
| bus_wdata | input | 32 | Store data |
| bus_we | input | 1 | Store strobe |
| bus_re | input | 1 | Load strobe |
| bus_rdata | output | 32 | Load data, valid the cycle after bus_re |
| tx_tok | output | 32 | Outbound token to the coprocessor |
| tx_avail | output | 1 | Outbound token is present |
| tx_take | input | 1 | Coprocessor consumes the outbound token |
| rx_data | input | 32 | Result token from the coprocessor |
| rx_push | input | 1 | Coprocessor writes a result token |
| rx_busy | output | 1 | Inbound slot holds an unread token |

## Verification
Every result is due exactly one clock edge after its stimulus.

| Result | Due |
|---|---|
| tx_tok, tx_avail | the edge that samples the store |
| rx_busy | the edge after the push or the data load |
| bus_rdata | the edge that samples bus_re |

The bench changes its inputs on falling edges and reads outputs on the next falling edge, half a cycle after the edge that must have produced them. With the copy coprocessor attached, the bench polls the status word instead of assuming a fixed round-trip latency. Every other check then samples at that single-edge delay.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_DATA = 2'd1,
    RD_STAT = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/mmio_decode.sv
module mmio_decode
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] TX_ADDR   = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] RX_ADDR   = 32'h8000_0004,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 32'h8000_0008
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              re,
  output logic              tx_store,
  output logic              rx_ack,
  output rd_sel_e           rd_sel
);
  logic hit_tx, hit_rx, hit_st;

  always_comb begin
    hit_tx   = (addr == TX_ADDR);
    hit_rx   = (addr == RX_ADDR);
    hit_st   = (addr == STAT_ADDR);
    // Stores to the read-only addresses produce no strobe (R8).
    tx_store = we && hit_tx;
    rx_ack   = re && hit_rx;
    if (re && hit_rx)      rd_sel = RD_DATA;
    else if (re && hit_st) rd_sel = RD_STAT;
    else                   rd_sel = RD_NONE;
  end
endmodule

// File: rtl/stream_tx_slot.sv
module stream_tx_slot #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              store,
  input  logic [DATA_W-1:0] store_data,
  input  logic              take,
  output logic [DATA_W-1:0] tok,
  output logic              avail,
  output logic              overrun
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tok     <= '0;
      avail   <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (store) begin
        tok   <= store_data;
        avail <= 1'b1;
        if (avail && !take) overrun <= 1'b1;
      end else if (take) begin
        avail <= 1'b0;
      end
    end
  end

  p_store_loads_r1: assert property (@(posedge clk) disable iff (rst)
    store |=> (avail && tok == $past(store_data)));

  p_take_empties_r2: assert property (@(posedge clk) disable iff (rst)
    (take && !store) |=> !avail);

  p_overrun_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  p_overrun_cause_r3: assert property (@(posedge clk) disable iff (rst)
    (store && avail && !take) |=> overrun);
endmodule

// File: rtl/stream_rx_slot.sv
module stream_rx_slot #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              ack,
  output logic [DATA_W-1:0] tok,
  output logic              busy
);
  logic accept;

  always_comb accept = push && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      tok  <= '0;
      busy <= 1'b0;
    end else if (accept) begin
      tok  <= push_data;
      busy <= 1'b1;
    end else if (ack) begin
      busy <= 1'b0;
    end
  end

  p_push_captures_r4: assert property (@(posedge clk) disable iff (rst)
    (push && !busy) |=> (busy && tok == $past(push_data)));

  p_push_ignored_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && !ack) |=> (busy && $stable(tok)));

  p_ack_empties_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && ack) |=> !busy);
endmodule

// File: rtl/mmio_stream_bridge.sv
module mmio_stream_bridge
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] TX_ADDR   = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] RX_ADDR   = 32'h8000_0004,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 32'h8000_0008
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] tx_tok,
  output logic              tx_avail,
  input  logic              tx_take,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_push,
  output logic              rx_busy
);
  localparam int STAT_PAD = DATA_W - 2;

  logic              tx_store, rx_ack, overrun;
  logic [DATA_W-1:0] rx_tok, status_w;
  rd_sel_e           rd_sel;

  mmio_decode #(
    .ADDR_W(ADDR_W), .TX_ADDR(TX_ADDR), .RX_ADDR(RX_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_dec (
    .addr(bus_addr), .we(bus_we), .re(bus_re),
    .tx_store(tx_store), .rx_ack(rx_ack), .rd_sel(rd_sel)
  );

  stream_tx_slot #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .store(tx_store), .store_data(bus_wdata),
    .take(tx_take), .tok(tx_tok), .avail(tx_avail), .overrun(overrun)
  );

  stream_rx_slot #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .push(rx_push), .push_data(rx_data),
    .ack(rx_ack), .tok(rx_tok), .busy(rx_busy)
  );

  always_comb status_w = {{STAT_PAD{1'b0}}, overrun, rx_busy};

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (rd_sel)
        RD_DATA: bus_rdata <= rx_tok;
        RD_STAT: bus_rdata <= status_w;
        default: bus_rdata <= '0;
      endcase
    end
  end

  p_idle_rdata_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> (bus_rdata == '0));

  p_data_load_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == RX_ADDR) |=> (bus_rdata == $past(rx_tok)));

  p_status_load_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == STAT_ADDR) |=> (bus_rdata[DATA_W-1:2] == '0
      && bus_rdata[0] == $past(rx_busy)));
endmodule

// File: tb/mmio_stream_bridge_tb_top.sv
module mmio_stream_bridge_tb_top;
  localparam logic [31:0] A_TX = 32'h8000_0000;
  localparam logic [31:0] A_RX = 32'h8000_0004;
  localparam logic [31:0] A_ST = 32'h8000_0008;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_rdata, tx_tok;
  logic        tx_avail, rx_busy;
  logic        tx_take, rx_push;
  logic [31:0] rx_data;

  logic        cp_en = 1'b0;
  logic        m_take = 1'b0, m_push = 1'b0;
  logic [31:0] m_data = '0;
  logic        cp_state = 1'b0;
  logic [31:0] cp_reg = '0;
  logic        cp_take, cp_push;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  // Two-state copy coprocessor: capture, then write out.
  always_comb begin
    cp_take = cp_en && !cp_state && tx_avail;
    cp_push = cp_en && cp_state && !rx_busy;
  end
  always @(posedge clk) begin
    if (rst || !cp_en) cp_state <= 1'b0;
    else if (cp_take) begin cp_reg <= tx_tok; cp_state <= 1'b1; end
    else if (cp_push) cp_state <= 1'b0;
  end

  assign tx_take = cp_en ? cp_take : m_take;
  assign rx_push = cp_en ? cp_push : m_push;
  assign rx_data = cp_en ? cp_reg  : m_data;

  mmio_stream_bridge dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .tx_tok(tx_tok), .tx_avail(tx_avail), .tx_take(tx_take),
    .rx_data(rx_data), .rx_push(rx_push), .rx_busy(rx_busy)
  );

  function automatic logic [31:0] exp_status(input logic busy, input logic ovr);
    return {30'd0, ovr, busy};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic bus_store(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic bus_load(input logic [31:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_re = 1'b1;
    @(negedge clk); v = bus_rdata; bus_re = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, val;
    void'($urandom(32'd1234));
    do_reset();

    // R9: reset state
    check("R9 tx_avail", {31'd0, tx_avail}, 32'd0);
    check("R9 rx_busy", {31'd0, rx_busy}, 32'd0);
    check("R9 rdata", bus_rdata, 32'd0);
    bus_load(A_ST, v); check("R9 status after reset", v, exp_status(0, 0));

    // R1: store pushes token
    bus_store(A_TX, 32'h1234_5678);
    check("R1 tx_avail", {31'd0, tx_avail}, 32'd1);
    check("R1 tx_tok", tx_tok, 32'h1234_5678);

    // R2: one-cycle take empties slot
    @(negedge clk); m_take = 1'b1;
    @(negedge clk); m_take = 1'b0;
    check("R2 tx_avail cleared", {31'd0, tx_avail}, 32'd0);
    bus_load(A_ST, v); check("R2 no overrun after clean take", v, exp_status(0, 0));

    // R3: overwrite while pending
    bus_store(A_TX, 32'hAAAA_0001);
    bus_store(A_TX, 32'hBBBB_0002);
    check("R3 tx_tok replaced", tx_tok, 32'hBBBB_0002);
    bus_load(A_ST, v); check("R3 R6 overrun bit", v, exp_status(0, 1));
    @(negedge clk); m_take = 1'b1;
    @(negedge clk); m_take = 1'b0;
    bus_load(A_ST, v); check("R3 overrun sticky", v, exp_status(0, 1));

    // R8: stores to read-only addresses ignored
    bus_store(A_RX, 32'hDEAD_BEEF);
    bus_store(A_ST, 32'hFFFF_FFFF);
    bus_store(32'h8000_0010, 32'h5555_5555);
    check("R8 tx_avail untouched", {31'd0, tx_avail}, 32'd0);
    check("R8 rx_busy untouched", {31'd0, rx_busy}, 32'd0);
    bus_load(A_ST, v); check("R8 status untouched", v, exp_status(0, 1));
    bus_load(A_RX, v); check("R8 rx token untouched", v, 32'd0);

    // R7: other address reads zero
    bus_load(32'h8000_000C, v); check("R7 unmapped load", v, 32'd0);
    @(negedge clk); check("R7 rdata idle", bus_rdata, 32'd0);

    // R4: push captures, second push ignored
    @(negedge clk); m_data = 32'hC0DE_0001; m_push = 1'b1;
    @(negedge clk); m_data = 32'hC0DE_0002;
    @(negedge clk); m_push = 1'b0;
    check("R4 rx_busy set", {31'd0, rx_busy}, 32'd1);
    bus_load(A_ST, v); check("R4 R6 status busy+overrun", v, exp_status(1, 1));

    // R5: data load returns first token and clears busy
    bus_load(A_RX, v); check("R4 R5 data load", v, 32'hC0DE_0001);
    check("R5 rx_busy cleared", {31'd0, rx_busy}, 32'd0);
    bus_load(A_ST, v); check("R6 status after load", v, exp_status(0, 1));

    // R10: copy coprocessor loopback, random values
    do_reset();
    cp_en = 1'b1;
    for (int i = 0; i < 5; i++) begin
      int polls;
      val = $urandom;
      if (i == 0) val = 32'hFFFF_FFFF;
      bus_store(A_TX, val);
      polls = 0;
      do begin
        bus_load(A_ST, v);
        polls++;
      end while (v[0] !== 1'b1 && polls < 50);
      check("R10 status ready", v, exp_status(1, 0));
      bus_load(A_RX, v); check("R10 value in order", v, val);
      bus_load(A_ST, v); check("R10 status zero between tokens", v, exp_status(0, 0));
    end
    cp_en = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule